// File: doc/BRIEF.md
# Calendar Real-Time Clock with Second Trim

This block keeps wall-clock time and a calendar. It advances on a one-cycle pulse that arrives once per second and holds seconds, minutes, hours, day of the week, day of the month, month and an 8-bit year. Carries ripple from seconds up through the year. Month lengths are observed. February gets a 29th day in every year whose value is a multiple of four, and that includes year zero.

Software loads any field through a write port that takes an address, a data byte and a strobe. It reads the fields back through a combinational read port.

Two trim inputs correct drift. A rising edge on the add-trim input makes the next seconds pulse advance the time by two seconds. A rising edge on the drop-trim input makes the next seconds pulse leave the time unchanged. Only one correction may be in flight at a time. After a correction is applied, a busy window lasts for two further seconds pulses, and new requests are refused while it is open. A request on both inputs in the same cycle is refused and raises an error flag.

Top module: `cal_clock`

## Requirements
- R1: After a synchronous reset the fields read seconds 0, minutes 0, hours 0, day-of-week 1, date 1, month 1 and year 0, with `trim_busy` and `trim_err` both low.
- R2: On each `tick_1hz` pulse with no trim pending, seconds advance by one. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0, where 0 is midnight.
- R3: Day-of-week counts 1 (Sunday) to 7. It advances only when hours wrap to 0, and it goes from 7 back to 1.
- R4: Date wraps to 1 and carries into month after the month's last day. That day is 30 for months 4, 6, 9 and 11, 29 for month 2 when year mod 4 is 0 (year 0 included), 28 for month 2 otherwise, and 31 for the other months. Month wraps from 12 to 1 and carries into year. Year wraps from 255 to 0.
- R5: With `wr_en` high, `wr_data` is stored into the field at `wr_addr`. The map is 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year. The value is truncated to the field width (6, 6, 5, 3, 5, 4, 8 bits). If a tick arrives in the same cycle, the other fields advance and the written field takes the written value. `rd_data` shows the field at `rd_addr` zero-extended through the same map, and address 7 reads 0.
- R6: A rising edge on `trim_up`, accepted while not busy, makes the next tick advance the time by two seconds with all carries.
- R7: A rising edge on `trim_dn`, accepted while not busy, makes the next tick leave every field unchanged.
- R8: `trim_busy` is high from the cycle after a request is accepted until the second tick after the tick that applied it. Trim edges seen while busy are dropped. A trim input held high for many cycles makes exactly one request.
- R9: Rising edges on both trim inputs in the same cycle while not busy make no request and set `trim_err`. `trim_err` stays set until a later single request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field index for writes |
| wr_data | input | 8 | Field write value |
| rd_addr | input | 3 | Field index for reads |
| rd_data | output | 8 | Selected field, zero-extended |
| trim_up | input | 1 | Add-one-second request (edge) |
| trim_dn | input | 1 | Drop-one-second request (edge) |
| trim_busy | output | 1 | Request pending or cool-down window open |
| trim_err | output | 1 | Simultaneous requests were refused |

## Verification
The bench targets these corner cases:
- The last second of a year, 255-12-31 23:59:59, where a missing carry would leave the date, month or year behind.
- February in years 0, 4 and 5. A leap test that ignored year zero, or tested the wrong bits, would give 29 or 28 days in the wrong year.
- A 30-day month, which would otherwise run on to day 31.
- An add trim at 23:59:58, which must cross midnight and move the day of week. A design that stepped the seconds by two without carrying would stop at an illegal seconds value.
- Held trim levels, requests during the cool-down window, and simultaneous requests. A design that detected levels instead of edges, or did not arbitrate, would apply extra corrections.
- A write that lands on a tick, which must keep the written value while the other fields still advance.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DOW_W  = 3;
    localparam int DATE_W = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 8;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DATE_W-1:0] date;
        logic [DOW_W-1:0]  dow;
        logic [HR_W-1:0]   hr;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    typedef enum logic [1:0] {
        TRIM_NONE = 2'd0,
        TRIM_ADD  = 2'd1,
        TRIM_DROP = 2'd2
    } trim_cmd_e;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HR   = 3'd2,
        FLD_DOW  = 3'd3,
        FLD_DATE = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6
    } fld_e;

    localparam cal_t CAL_RESET = '{year: '0, mon: 4'd1, date: 5'd1, dow: 3'd1,
                                   hr: '0, min: '0, sec: '0};

    function automatic logic [DATE_W-1:0] month_days(logic [MON_W-1:0] mon,
                                                     logic [YEAR_W-1:0] year);
        logic [DATE_W-1:0] d;
        case (mon)
            4'd2:                      d = (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
            default:                   d = 5'd31;
        endcase
        return d;
    endfunction

    function automatic cal_t step_second(cal_t t);
        cal_t n;
        n = t;
        if (t.sec >= 6'd59) begin
            n.sec = '0;
            if (t.min >= 6'd59) begin
                n.min = '0;
                if (t.hr >= 5'd23) begin
                    n.hr  = '0;
                    n.dow = (t.dow >= 3'd7) ? 3'd1 : t.dow + 3'd1;
                    if (t.date >= month_days(t.mon, t.year)) begin
                        n.date = 5'd1;
                        if (t.mon >= 4'd12) begin
                            n.mon  = 4'd1;
                            n.year = t.year + 8'd1;
                        end else begin
                            n.mon = t.mon + 4'd1;
                        end
                    end else begin
                        n.date = t.date + 5'd1;
                    end
                end else begin
                    n.hr = t.hr + 5'd1;
                end
            end else begin
                n.min = t.min + 6'd1;
            end
        end else begin
            n.sec = t.sec + 6'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/cal_trim.sv
module cal_trim
    import cal_pkg::*;
#(
    parameter int BUSY_TICKS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      trim_up,
    input  logic      trim_dn,
    output trim_cmd_e cmd,
    output logic      busy,
    output logic      err
);
    localparam int CNT_W = $clog2(BUSY_TICKS + 1);

    logic             up_q, dn_q;
    logic             up_rise, dn_rise;
    logic [CNT_W-1:0] win;

    assign up_rise = trim_up & ~up_q;
    assign dn_rise = trim_dn & ~dn_q;
    assign busy    = (cmd != TRIM_NONE) || (win != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
            cmd  <= TRIM_NONE;
            win  <= '0;
            err  <= 1'b0;
        end else begin
            up_q <= trim_up;
            dn_q <= trim_dn;
            if (tick) begin
                if (cmd != TRIM_NONE) begin
                    cmd <= TRIM_NONE;
                    win <= CNT_W'(BUSY_TICKS);
                end else if (win != '0) begin
                    win <= win - 1'b1;
                end
            end
            if (!busy) begin
                if (up_rise && dn_rise) begin
                    err <= 1'b1;
                end else if (up_rise) begin
                    cmd <= TRIM_ADD;
                    err <= 1'b0;
                end else if (dn_rise) begin
                    cmd <= TRIM_DROP;
                    err <= 1'b0;
                end
            end
        end
    end

    AST_BOTH_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (up_rise && dn_rise && !busy) |=> (err && cmd == TRIM_NONE)); // R9

    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd == TRIM_NONE && (up_rise || dn_rise)) |=> (cmd == TRIM_NONE)); // R8

    AST_APPLY_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (tick && cmd != TRIM_NONE) |=> (cmd == TRIM_NONE && busy)); // R8

endmodule

// File: rtl/cal_core.sv
module cal_core
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  trim_cmd_e         cmd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cal_t              now
);
    cal_t cur, adv1, adv2, nxt;

    always_comb begin
        adv1 = step_second(cur);
        adv2 = step_second(adv1);
        nxt  = cur;
        if (tick) begin
            case (cmd)
                TRIM_DROP: nxt = cur;
                TRIM_ADD:  nxt = adv2;
                default:   nxt = adv1;
            endcase
        end
        if (wr_en) begin
            case (wr_addr)
                FLD_SEC:  nxt.sec  = wr_data[SEC_W-1:0];
                FLD_MIN:  nxt.min  = wr_data[MIN_W-1:0];
                FLD_HR:   nxt.hr   = wr_data[HR_W-1:0];
                FLD_DOW:  nxt.dow  = wr_data[DOW_W-1:0];
                FLD_DATE: nxt.date = wr_data[DATE_W-1:0];
                FLD_MON:  nxt.mon  = wr_data[MON_W-1:0];
                FLD_YEAR: nxt.year = wr_data[YEAR_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CAL_RESET;
        else     cur <= nxt;
    end

    assign now = cur;

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cmd == TRIM_NONE && cur.sec < 6'd59)
        |=> (cur.sec == $past(cur.sec) + 6'd1 && cur.min == $past(cur.min))); // R2

    AST_MIDNIGHT: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cmd == TRIM_NONE && cur.hr == 5'd23 && cur.min == 6'd59 && cur.sec == 6'd59)
        |=> (cur.hr == '0 && cur.min == '0 && cur.sec == '0 && cur.dow != $past(cur.dow))); // R3

    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cmd == TRIM_DROP) |=> $stable(cur)); // R7

    AST_ADD_TWO: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cmd == TRIM_ADD && cur.sec < 6'd58)
        |=> (cur.sec == $past(cur.sec) + 6'd2)); // R6

endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       trim_up,
    input  logic       trim_dn,
    output logic       trim_busy,
    output logic       trim_err
);
    trim_cmd_e cmd;
    cal_t      now;

    cal_trim #(.BUSY_TICKS(2)) u_trim (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .trim_up (trim_up),
        .trim_dn (trim_dn),
        .cmd     (cmd),
        .busy    (trim_busy),
        .err     (trim_err)
    );

    cal_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .cmd     (cmd),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .now     (now)
    );

    always_comb begin
        case (rd_addr)
            FLD_SEC:  rd_data = DATA_W'(now.sec);
            FLD_MIN:  rd_data = DATA_W'(now.min);
            FLD_HR:   rd_data = DATA_W'(now.hr);
            FLD_DOW:  rd_data = DATA_W'(now.dow);
            FLD_DATE: rd_data = DATA_W'(now.date);
            FLD_MON:  rd_data = DATA_W'(now.mon);
            FLD_YEAR: rd_data = DATA_W'(now.year);
            default:  rd_data = '0;
        endcase
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (now == CAL_RESET && !trim_busy && !trim_err)); // R1

endmodule

// File: tb/cal_clock_bench.sv
`timescale 1ns/1ps
module cal_clock_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       trim_up = 1'b0;
    logic       trim_dn = 1'b0;
    logic       trim_busy, trim_err;

    always #2 clk = ~clk;

    cal_clock u_cal_clock (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trim_up(trim_up), .trim_dn(trim_dn), .trim_busy(trim_busy), .trim_err(trim_err)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string req = "R1";
    logic  up_lvl = 1'b0;
    logic  dn_lvl = 1'b0;

    // behavioural reference state
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_year;
    int m_pend, m_win, m_err;
    logic p_up, p_dn;

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic madv();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > mdays(m_mon, m_year)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_year = (m_year + 1) % 256;
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_year = 0;
            m_pend = 0; m_win = 0; m_err = 0; p_up = 1'b0; p_dn = 1'b0;
        end else begin
            automatic logic ue = trim_up && !p_up;
            automatic logic de = trim_dn && !p_dn;
            automatic logic was_busy = (m_pend != 0) || (m_win != 0);
            if (tick_1hz) begin
                if (m_pend == 2) begin
                    m_pend = 0; m_win = 2;
                end else if (m_pend == 1) begin
                    madv(); madv(); m_pend = 0; m_win = 2;
                end else begin
                    madv();
                    if (m_win > 0) m_win--;
                end
            end
            if (!was_busy) begin
                if (ue && de) m_err = 1;
                else if (ue) begin m_pend = 1; m_err = 0; end
                else if (de) begin m_pend = 2; m_err = 0; end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_sec  = wr_data & 8'h3f;
                    3'd1: m_min  = wr_data & 8'h3f;
                    3'd2: m_hr   = wr_data & 8'h1f;
                    3'd3: m_dow  = wr_data & 8'h07;
                    3'd4: m_date = wr_data & 8'h1f;
                    3'd5: m_mon  = wr_data & 8'h0f;
                    3'd6: m_year = int'(wr_data);
                    default: ;
                endcase
            end
            p_up = trim_up; p_dn = trim_dn;
        end
    end

    function automatic int mfield(logic [2:0] a);
        case (a)
            3'd0: return m_sec;
            3'd1: return m_min;
            3'd2: return m_hr;
            3'd3: return m_dow;
            3'd4: return m_date;
            3'd5: return m_mon;
            3'd6: return m_year;
            default: return 0;
        endcase
    endfunction

    task automatic compare_now();
        automatic int  exp_d = mfield(rd_addr);
        automatic logic exp_b = (m_pend != 0) || (m_win != 0);
        n_cmp++;
        if (int'(rd_data) != exp_d || trim_busy !== exp_b || trim_err !== (m_err != 0)) begin
            n_bad++;
            $display("FAIL %s: addr %0d data %0d busy %0b err %0b, expected data %0d busy %0b err %0b",
                     req, rd_addr, rd_data, trim_busy, trim_err, exp_d, exp_b, m_err);
        end
    endtask

    // one cycle: check outputs, then drive inputs for the next edge
    task automatic cyc(input logic tk, input logic we, input logic [2:0] wa, input logic [7:0] wd);
        @(negedge clk);
        compare_now();
        rd_addr  = rd_addr + 3'd1;
        tick_1hz = tk;
        wr_en    = we;
        wr_addr  = wa;
        wr_data  = wd;
        trim_up  = up_lvl;
        trim_dn  = dn_lvl;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 8'd0);
    endtask

    task automatic tick_once();
        cyc(1'b1, 1'b0, 3'd0, 8'd0);
        idle(8);
    endtask

    task automatic put(input logic [2:0] a, input int v);
        cyc(1'b0, 1'b1, a, 8'(v));
    endtask

    task automatic set_all(input int y, input int mo, input int d, input int w,
                           input int h, input int mi, input int s);
        put(3'd6, y); put(3'd5, mo); put(3'd4, d); put(3'd3, w);
        put(3'd2, h); put(3'd1, mi); put(3'd0, s);
        idle(8);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung, expected done");
        finish_run();
    end

    initial begin
        // R1 reset state
        req = "R1";
        idle(3);
        rst = 1'b0;
        idle(10);

        // R2 seconds/minutes/hours rollover
        req = "R2";
        set_all(10, 3, 5, 2, 22, 58, 50);
        for (int i = 0; i < 75; i++) tick_once();
        set_all(10, 3, 5, 2, 23, 59, 58);
        tick_once(); tick_once(); tick_once();

        // R3 day-of-week 7 -> 1 at midnight
        req = "R3";
        set_all(10, 3, 5, 7, 23, 59, 59);
        tick_once();
        set_all(10, 3, 9, 3, 12, 59, 59);
        tick_once();

        // R4 month lengths and leap rule
        req = "R4";
        set_all(4, 2, 28, 1, 23, 59, 59);  tick_once();
        put(3'd2, 23); put(3'd1, 59); put(3'd0, 59); idle(8); tick_once();
        set_all(0, 2, 28, 1, 23, 59, 59);  tick_once();
        set_all(5, 2, 28, 1, 23, 59, 59);  tick_once();
        set_all(8, 4, 30, 1, 23, 59, 59);  tick_once();
        set_all(8, 11, 30, 1, 23, 59, 59); tick_once();
        set_all(8, 1, 31, 1, 23, 59, 59);  tick_once();
        set_all(255, 12, 31, 6, 23, 59, 59); tick_once(); tick_once();

        // R5 write landing on tick, truncation, unused read address
        req = "R5";
        set_all(20, 6, 10, 4, 10, 20, 30);
        cyc(1'b1, 1'b1, 3'd1, 8'd45); idle(8);
        cyc(1'b1, 1'b1, 3'd0, 8'd7);  idle(8);
        put(3'd4, 8'hE3); idle(8);
        put(3'd7, 8'h55); idle(8);

        // R6 add trim, with carries over midnight
        req = "R6";
        set_all(30, 7, 31, 7, 23, 59, 58);
        up_lvl = 1'b1; idle(6);
        tick_once(); up_lvl = 1'b0; tick_once(); tick_once(); tick_once();
        set_all(30, 8, 2, 1, 1, 0, 59);
        up_lvl = 1'b1; idle(2); up_lvl = 1'b0; idle(2);
        tick_once(); tick_once(); tick_once();

        // R7 drop trim
        req = "R7";
        up_lvl = 1'b0;
        dn_lvl = 1'b1; idle(3); dn_lvl = 1'b0; idle(2);
        tick_once(); tick_once(); tick_once(); tick_once();

        // R8 busy window, held level makes one request, edges while busy dropped
        req = "R8";
        up_lvl = 1'b1; idle(20);
        tick_once();
        up_lvl = 1'b0; idle(2); up_lvl = 1'b1; idle(2); up_lvl = 1'b0;
        dn_lvl = 1'b1; idle(2); dn_lvl = 1'b0;
        tick_once();
        dn_lvl = 1'b1; idle(2); dn_lvl = 1'b0;
        tick_once(); tick_once(); tick_once();

        // R9 simultaneous requests
        req = "R9";
        up_lvl = 1'b1; dn_lvl = 1'b1; idle(3);
        up_lvl = 1'b0; dn_lvl = 1'b0; idle(2);
        tick_once(); tick_once();
        dn_lvl = 1'b1; idle(2); dn_lvl = 1'b0;
        tick_once(); tick_once(); tick_once();

        idle(8);
        finish_run();
    end
endmodule